// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block sits beside a processor whose bus control is delegated to an external controller, as in a multi-processor board. It samples the three status lines the processor drives and, from nothing but that 3-bit code, produces the address-latch pulse, the memory and I/O read and write strobes, the interrupt-acknowledge strobe, the data-transceiver direction and enable, and a halt indication. A bus cycle is recognised when the status leaves the passive code for any active code.

The generated cycle follows T1, T2, T3, optional wait states TW, and T4. The address-latch pulse occupies T1, so the address is captured on its falling edge. Read-type commands open in T2 and write commands in T3. Both close at the end of T3 or the last TW. The slave's ready line, sampled at the end of T3 and of each TW, stretches the command by inserting wait states. All command outputs are active high. The direction output is high for transmit (write) and low for receive (read).

Top module: `status_bus_ctrl`

## Requirements
- R1: While rst_ni is low and right after reset, every strobe, den_o and halt_o are low and dt_r_o is high.
- R2: A cycle starts only when the sampled status moves from passive (3'b111) to an active code. ale_o is then high for exactly one clock (T1), which begins two clock edges after the new code is applied. A change from one active code to another starts nothing.
- R3: The status code selects the strobe: 3'b000 inta_o, 3'b001 io_rd_o, 3'b010 io_wr_o, 3'b011 halt (no strobe), 3'b100 and 3'b101 mem_rd_o, 3'b110 mem_wr_o.
- R4: Read-type strobes (codes 000, 001, 100, 101) are high in T2, T3 and every TW, and low in T1 and T4.
- R5: Write strobes (codes 010, 110) are high in T3 and every TW only.
- R6: ready_i low at the end of T3 or a TW inserts another TW. ready_i high there moves the cycle to T4.
- R7: dt_r_o is low from T1 through T4 of a read-type cycle and high at all other times.
- R8: den_o is high in T3, TW and T4 of every cycle except halt, and low otherwise.
- R9: A halt cycle drives no strobe and no den_o. halt_o rises at T2 of that cycle and stays high until the clock on which the next cycle's T1 begins.
- R10: At most one of the five command strobes is high in any clock.
- R11: A new start detected during T4 or earlier in a cycle is held, and T4 is followed directly by T1 of the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_i | input | 3 | Processor status code |
| ready_i | input | 1 | Slave ready, low requests wait states |
| ale_o | output | 1 | Address-latch pulse in T1 |
| mem_rd_o | output | 1 | Memory read / fetch command |
| mem_wr_o | output | 1 | Memory write command |
| io_rd_o | output | 1 | I/O read command |
| io_wr_o | output | 1 | I/O write command |
| inta_o | output | 1 | Interrupt-acknowledge command |
| dt_r_o | output | 1 | Transceiver direction, 1 transmit, 0 receive |
| den_o | output | 1 | Transceiver enable for the data phase |
| halt_o | output | 1 | Processor halted indication |

## Verification
The assertions assume that status and ready change away from the rising clock edge. They also assume the processor returns to the passive code between cycles, so that a start is never detected while another start is still pending. The bench drives every input on the falling edge. It holds each active code only until T1 and then restores passive, or, in the two sequences built for R2 and R11, it changes code at controlled phases. This keeps at most one pending start at any time.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MEMRD   = 3'b101,
    ST_MEMWR   = 3'b110,
    ST_PASSIVE = 3'b111
  } stat_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef struct packed {
    logic ale;
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic inta;
    logic dt_r;
    logic den;
  } cmd_t;

  function automatic logic is_read(stat_e c);
    return (c == ST_INTA) || (c == ST_IORD) || (c == ST_FETCH) || (c == ST_MEMRD);
  endfunction

  function automatic logic is_write(stat_e c);
    return (c == ST_IOWR) || (c == ST_MEMWR);
  endfunction

endpackage

// File: rtl/bcc_status_sampler.sv
module bcc_status_sampler
  import bcc_pkg::*;
#(
  parameter int SYNC_DEPTH = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] stat_i,
  input  logic       take_i,
  output logic       start_o,
  output logic       go_o,
  output stat_e      code_o
);

  localparam int LAST = SYNC_DEPTH - 1;

  logic [2:0] chain_q [SYNC_DEPTH];
  logic [2:0] prev_q;
  logic       pend_q;
  stat_e      code_q;
  logic       start;

  for (genvar g = 0; g < SYNC_DEPTH; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= ST_PASSIVE;
        else         chain_q[g] <= stat_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= ST_PASSIVE;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= ST_PASSIVE;
    else         prev_q <= chain_q[LAST];
  end

  // leaving passive marks a new cycle
  assign start = (prev_q == ST_PASSIVE) && (chain_q[LAST] != ST_PASSIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      code_q <= ST_PASSIVE;
    end else begin
      pend_q <= (pend_q | start) & ~take_i;
      if (start) code_q <= stat_e'(chain_q[LAST]);
    end
  end

  assign start_o = start;
  assign go_o    = start | pend_q;
  assign code_o  = start ? stat_e'(chain_q[LAST]) : code_q;

endmodule

// File: rtl/bcc_cycle_fsm.sv
module bcc_cycle_fsm
  import bcc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   go_i,
  input  stat_e  code_i,
  input  logic   ready_i,
  output logic   take_o,
  output phase_e phase_o,
  output stat_e  code_o
);

  phase_e ph_q, ph_d;
  stat_e  code_q;

  assign take_o = go_i && ((ph_q == PH_IDLE) || (ph_q == PH_T4));

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (take_o) ph_d = PH_T1;
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3:   ph_d = ready_i ? PH_T4 : PH_TW;
      PH_TW:   ph_d = ready_i ? PH_T4 : PH_TW;
      PH_T4:   ph_d = take_o ? PH_T1 : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      code_q <= ST_PASSIVE;
    end else begin
      ph_q <= ph_d;
      if (take_o) code_q <= code_i;
    end
  end

  assign phase_o = ph_q;
  assign code_o  = code_q;

  a_r6_wait_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_T3) || (ph_q == PH_TW)) && !ready_i |=> ph_q == PH_TW);

  a_r6_wait_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_T3) || (ph_q == PH_TW)) && ready_i |=> ph_q == PH_T4);

  a_r11_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_T4) && go_i |=> ph_q == PH_T1);

endmodule

// File: rtl/bcc_cmd_decode.sv
module bcc_cmd_decode
  import bcc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  input  stat_e  code_i,
  input  logic   start_i,
  output cmd_t   cmd_o,
  output logic   halt_o
);

  logic rd, wr, rd_win, wr_win, strobe, data_ph, halt_q;

  assign rd      = is_read(code_i);
  assign wr      = is_write(code_i);
  assign rd_win  = (phase_i == PH_T2) || (phase_i == PH_T3) || (phase_i == PH_TW);
  assign wr_win  = (phase_i == PH_T3) || (phase_i == PH_TW);
  assign data_ph = wr_win || (phase_i == PH_T4);
  assign strobe  = (rd && rd_win) || (wr && wr_win);

  always_comb begin
    cmd_o        = '0;
    cmd_o.ale    = (phase_i == PH_T1);
    cmd_o.mem_rd = strobe && ((code_i == ST_FETCH) || (code_i == ST_MEMRD));
    cmd_o.mem_wr = strobe && (code_i == ST_MEMWR);
    cmd_o.io_rd  = strobe && (code_i == ST_IORD);
    cmd_o.io_wr  = strobe && (code_i == ST_IOWR);
    cmd_o.inta   = strobe && (code_i == ST_INTA);
    cmd_o.dt_r   = !(rd && (phase_i != PH_IDLE));
    cmd_o.den    = data_ph && (code_i != ST_HALT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          halt_q <= 1'b0;
    else if (start_i)                                     halt_q <= 1'b0;
    else if ((phase_i == PH_T1) && (code_i == ST_HALT))   halt_q <= 1'b1;
  end

  assign halt_o = halt_q;

  a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_o.mem_rd, cmd_o.mem_wr, cmd_o.io_rd, cmd_o.io_wr, cmd_o.inta}));

  a_r9_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && (phase_i != PH_T1) |->
      !(cmd_o.mem_rd || cmd_o.mem_wr || cmd_o.io_rd || cmd_o.io_wr || cmd_o.inta || cmd_o.den));

  a_r2_ale_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o.ale |=> !cmd_o.ale);

  a_r8_den_after_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o.ale |-> !cmd_o.den);

endmodule

// File: rtl/status_bus_ctrl.sv
module status_bus_ctrl
  import bcc_pkg::*;
#(
  parameter int SYNC_DEPTH = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] stat_i,
  input  logic       ready_i,
  output logic       ale_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       io_rd_o,
  output logic       io_wr_o,
  output logic       inta_o,
  output logic       dt_r_o,
  output logic       den_o,
  output logic       halt_o
);

  logic   start, go, take;
  stat_e  new_code, cur_code;
  phase_e phase;
  cmd_t   cmd;

  bcc_status_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) u_samp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stat_i  (stat_i),
    .take_i  (take),
    .start_o (start),
    .go_o    (go),
    .code_o  (new_code)
  );

  bcc_cycle_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .code_i  (new_code),
    .ready_i (ready_i),
    .take_o  (take),
    .phase_o (phase),
    .code_o  (cur_code)
  );

  bcc_cmd_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .code_i  (cur_code),
    .start_i (start),
    .cmd_o   (cmd),
    .halt_o  (halt_o)
  );

  assign ale_o    = cmd.ale;
  assign mem_rd_o = cmd.mem_rd;
  assign mem_wr_o = cmd.mem_wr;
  assign io_rd_o  = cmd.io_rd;
  assign io_wr_o  = cmd.io_wr;
  assign inta_o   = cmd.inta;
  assign dt_r_o   = cmd.dt_r;
  assign den_o    = cmd.den;

endmodule

// File: tb/sim_status_bus_ctrl.sv
module sim_status_bus_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int PASSIVE = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] stat = 3'b111;
  logic ready = 1'b1;
  logic ale, mem_rd, mem_wr, io_rd, io_wr, inta, dt_r, den, halt;
  int checks = 0;
  int failures = 0;
  bit halt_e = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_bus_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .stat_i(stat), .ready_i(ready),
    .ale_o(ale), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .io_rd_o(io_rd),
    .io_wr_o(io_wr), .inta_o(inta), .dt_r_o(dt_r), .den_o(den), .halt_o(halt)
  );

  // order: ale mem_rd mem_wr io_rd io_wr inta dt_r den halt
  function automatic logic [8:0] exp_out(int code, int ph, bit h);
    bit rd, wr, s;
    rd = (code == 0) || (code == 1) || (code == 4) || (code == 5);
    wr = (code == 2) || (code == 6);
    s  = (rd && (ph == 2 || ph == 3 || ph == 4)) || (wr && (ph == 3 || ph == 4));
    return {ph == 1, s && (code == 4 || code == 5), s && code == 6, s && code == 1,
            s && code == 2, s && code == 0, !(rd && ph != 0),
            (ph == 3 || ph == 4 || ph == 5) && code != 3, h};
  endfunction

  function automatic logic [8:0] act();
    return {ale, mem_rd, mem_wr, io_rd, io_wr, inta, dt_r, den, halt};
  endfunction

  task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_phase(string req, int code, int ph);
    chk($sformatf("%s code=%0d phase=%0d", req, code, ph), act(), exp_out(code, ph, halt_e));
    if (ph == 3) begin
      checks++;
      if ($countones({mem_rd, mem_wr, io_rd, io_wr, inta}) > 1) begin
        failures++;
        $display("FAIL R10: %0d strobes high, expected at most 1",
                 $countones({mem_rd, mem_wr, io_rd, io_wr, inta}));
      end
    end
  endtask

  // enters just after a negedge with the controller idle
  task automatic run_cycle(int code, int waits);
    stat = 3'(code);
    ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    halt_e = 1'b0;
    chk_phase("R2 R3 R7 T1", code, 1);
    stat = 3'(PASSIVE);
    ready = (waits == 0);
    @(negedge clk);
    if (code == 3) halt_e = 1'b1;
    chk_phase("R3 R4 R9 T2", code, 2);
    @(negedge clk);
    chk_phase("R3 R5 R8 T3", code, 3);
    for (int i = 1; i <= waits; i++) begin
      @(negedge clk);
      chk_phase("R6 R4 R5 TW", code, 4);
      if (i == waits) ready = 1'b1;
    end
    @(negedge clk);
    chk_phase("R3 R4 R8 T4", code, 5);
    @(negedge clk);
    chk_phase("R9 R7 idle", code, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", act(), {1'b0, 5'b0, 1'b1, 1'b0, 1'b0});
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", act(), {1'b0, 5'b0, 1'b1, 1'b0, 1'b0});

    for (int w = 0; w < 3; w++)
      for (int c = 0; c < 7; c++)
        run_cycle(c, (w == 2) ? 3 : w);

    // R2: active-to-active change starts nothing
    stat = 3'(6);
    @(negedge clk);
    @(negedge clk);
    halt_e = 1'b0;
    chk_phase("R2 T1", 6, 1);
    stat = 3'(5);
    @(negedge clk); chk_phase("R2 T2", 6, 2);
    @(negedge clk); chk_phase("R2 T3", 6, 3);
    @(negedge clk); chk_phase("R2 T4", 6, 4 + 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_phase("R2 no restart", 6, 0);
    end
    stat = 3'(PASSIVE);
    @(negedge clk);
    @(negedge clk);

    // R11: next code arrives during T3, T1 follows T4 directly
    stat = 3'(1);
    @(negedge clk);
    @(negedge clk);
    chk_phase("R11 first T1", 1, 1);
    stat = 3'(PASSIVE);
    @(negedge clk); chk_phase("R11 first T2", 1, 2);
    @(negedge clk); chk_phase("R11 first T3", 1, 3);
    stat = 3'(6);
    @(negedge clk); chk_phase("R11 first T4", 1, 5);
    @(negedge clk); chk_phase("R11 second T1", 6, 1);
    stat = 3'(PASSIVE);
    @(negedge clk); chk_phase("R11 second T2", 6, 2);
    @(negedge clk); chk_phase("R11 second T3", 6, 3);
    @(negedge clk); chk_phase("R11 second T4", 6, 5);
    @(negedge clk); chk_phase("R11 idle", 6, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule